// File: doc/BRIEF.md
# RGB565 Pixel Pack, Unpack and Alpha Blend Unit

This unit converts colour between separate channel values and a 16-bit 5-6-5 pixel word. A pack request turns red, green and blue values into one word. An unpack request splits a word back into its three channels. Both results appear one cycle after the request is accepted.

A blend request lays a new colour over the pixel word held in an attached memory, using an 8-bit alpha. The unit reads the stored word, unpacks it and mixes each channel. It then packs the mixed result and writes it back, and raises a one-cycle done pulse. The memory port is a single word with a read latency of one cycle. Address calculation and arbitration are handled outside the unit.

A per-request mirror flag selects a storage form in which the bits of each channel are reversed inside that channel's own field. The flag applies to packing, to unpacking, and to both halves of a blend.

Top module: `px565_unit`

## Requirements
- R1: Operation code 2'b00 (pack) gives `out_word` = {blue, green, red}, with blue in bits 15:11, green in bits 10:5 and red in bits 4:0. `out_valid` is high for exactly the cycle after acceptance.
- R2: Operation code 2'b01 (unpack) gives `out_r` = word[4:0], `out_g` = word[10:5] and `out_b` = word[15:11], presented with `out_valid` in the cycle after acceptance.
- R3: With `req_mirror` high, pack and unpack reverse the bits of each channel inside its own field. For example, blue 1 sets bit 15, green 1 sets bit 10 and red 1 sets bit 4.
- R4: Operation code 2'b10 (blend) writes back, per channel, (new*alpha + old*(255-alpha)) >> 8. Here old is the channel unpacked from the stored word.
- R5: A blend drives `mem_rd` for the single cycle after acceptance. The unit takes `mem_rdata` in the cycle after `mem_rd`, and drives `mem_wr` for one cycle, two cycles after `mem_rd`.
- R6: `done` is high for exactly the one cycle after `mem_wr`. `req_ready` is low from the cycle after blend acceptance through the `done` cycle, and high again the cycle after.
- R7: A request presented while `req_ready` is low is ignored. It produces no `out_valid` and no memory access.
- R8: In a blend with `req_mirror` high, the stored word is unmirrored before mixing and the result is mirrored before the write.
- R9: In reset, and directly after it, `req_ready` is 1 and `out_valid`, `mem_rd`, `mem_wr` and `done` are 0.
- R10: Operation code 2'b11 is ignored. It produces no `out_valid`, no memory access and no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 00 pack, 01 unpack, 10 blend, 11 none |
| req_mirror | input | 1 | Per-channel bit-mirror storage form |
| req_r | input | 5 | Red channel |
| req_g | input | 6 | Green channel |
| req_b | input | 5 | Blue channel |
| req_alpha | input | 8 | Blend weight of the new colour |
| req_word | input | 16 | Word to unpack |
| req_ready | output | 1 | Unit can accept a request |
| out_valid | output | 1 | Pack/unpack result valid |
| out_word | output | 16 | Packed word |
| out_r | output | 5 | Unpacked red |
| out_g | output | 6 | Unpacked green |
| out_b | output | 5 | Unpacked blue |
| mem_rd | output | 1 | Read of the stored pixel |
| mem_wr | output | 1 | Write of the blended pixel |
| mem_wdata | output | 16 | Blended word |
| mem_rdata | input | 16 | Stored word, valid the cycle after `mem_rd` |
| done | output | 1 | Blend write completed |

## Verification
Pack and unpack are driven with random channel values in both storage forms. Single-bit and all-ones values then separate a correct field order from a swapped red/blue layout or a wrong mirror. Blends use random colours, alphas and stored words, plus alpha 0, alpha 255 and all-ones extremes. These separate the 255-complement weight from a 256-complement weight and show whether the mirror is undone before mixing. A pack request held high during a blend shows that busy-time requests are dropped, and an op code of 11 shows that the spare code does nothing.

// File: rtl/px565_unit.sv
module px565_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_op,
  input  logic        req_mirror,
  input  logic [4:0]  req_r,
  input  logic [5:0]  req_g,
  input  logic [4:0]  req_b,
  input  logic [7:0]  req_alpha,
  input  logic [15:0] req_word,
  output logic        req_ready,
  output logic        out_valid,
  output logic [15:0] out_word,
  output logic [4:0]  out_r,
  output logic [5:0]  out_g,
  output logic [4:0]  out_b,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  output logic        done
);
  localparam logic [1:0] OP_PACK = 2'b00, OP_UNPACK = 2'b01, OP_BLEND = 2'b10;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_CALC, S_WR, S_FIN} st_t;
  st_t st;

  logic       mir;
  logic [4:0] nr, nb;
  logic [5:0] ng;
  logic [7:0] na;

  function automatic logic [4:0] flip5(input logic [4:0] v);
    for (int i = 0; i < 5; i++) flip5[i] = v[4-i];
  endfunction

  function automatic logic [5:0] flip6(input logic [5:0] v);
    for (int i = 0; i < 6; i++) flip6[i] = v[5-i];
  endfunction

  function automatic logic [15:0] pack(input logic [4:0] r, input logic [5:0] g,
                                       input logic [4:0] b, input logic m);
    pack = m ? {flip5(b), flip6(g), flip5(r)} : {b, g, r};
  endfunction

  function automatic logic [5:0] mix(input logic [5:0] n, input logic [5:0] o, input logic [7:0] a);
    logic [14:0] t;
    t = n * a + o * (8'd255 - a);
    mix = t[13:8];
  endfunction

  logic [4:0] ur, ub, or_, ob;
  logic [5:0] ug, og;
  assign ur = req_mirror ? flip5(req_word[4:0])   : req_word[4:0];
  assign ug = req_mirror ? flip6(req_word[10:5])  : req_word[10:5];
  assign ub = req_mirror ? flip5(req_word[15:11]) : req_word[15:11];
  assign or_ = mir ? flip5(mem_rdata[4:0])   : mem_rdata[4:0];
  assign og  = mir ? flip6(mem_rdata[10:5])  : mem_rdata[10:5];
  assign ob  = mir ? flip5(mem_rdata[15:11]) : mem_rdata[15:11];

  logic [5:0] mr, mg, mb;
  assign mr = mix({1'b0, nr}, {1'b0, or_}, na);
  assign mg = mix(ng, og, na);
  assign mb = mix({1'b0, nb}, {1'b0, ob}, na);

  logic take;
  assign req_ready = (st == S_IDLE);
  assign take      = req_valid && req_ready;
  assign mem_rd    = (st == S_RD);
  assign mem_wr    = (st == S_WR);
  assign done      = (st == S_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      out_valid <= 1'b0;
      out_word  <= '0;
      out_r     <= '0;
      out_g     <= '0;
      out_b     <= '0;
      mem_wdata <= '0;
      mir       <= 1'b0;
      nr        <= '0;
      ng        <= '0;
      nb        <= '0;
      na        <= '0;
    end else begin
      out_valid <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          case (req_op)
            OP_PACK: begin
              out_valid <= 1'b1;
              out_word  <= pack(req_r, req_g, req_b, req_mirror);
            end
            OP_UNPACK: begin
              out_valid <= 1'b1;
              out_r     <= ur;
              out_g     <= ug;
              out_b     <= ub;
            end
            OP_BLEND: begin
              st  <= S_RD;
              mir <= req_mirror;
              nr  <= req_r;
              ng  <= req_g;
              nb  <= req_b;
              na  <= req_alpha;
            end
            default: ;
          endcase
        end
        S_RD:   st <= S_CALC;
        S_CALC: begin
          mem_wdata <= pack(mr[4:0], mg, mb[4:0], mir);
          st        <= S_WR;
        end
        S_WR:   st <= S_FIN;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module px565_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] req_op,
  input logic       req_ready,
  input logic       out_valid,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       done
);
  a_r1_pack_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'b00) |=> out_valid);
  a_r5_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd && !mem_wr);
  a_r5_blend_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'b10) |=> mem_rd);
  a_r6_done_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> done);
  a_r6_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);
  a_r7_busy_no_out: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> !out_valid);
  a_r10_spare_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'b11) |=> !out_valid && !mem_rd);
  a_r5_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr) && !(mem_wr && done));
endmodule

bind px565_unit px565_sva u_sva (.*);

// File: tb/sim_px565_unit.sv
`timescale 1ns/1ps
module sim_px565_unit;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic req_valid = 0, req_mirror = 0;
  logic [1:0] req_op = 0;
  logic [4:0] req_r = 0, req_b = 0;
  logic [5:0] req_g = 0;
  logic [7:0] req_alpha = 0;
  logic [15:0] req_word = 0;
  logic req_ready, out_valid, mem_rd, mem_wr, done;
  logic [15:0] out_word, mem_wdata;
  logic [4:0] out_r, out_b;
  logic [5:0] out_g;
  logic [15:0] stored = 0, rdata = 0, load_val = 0;
  logic load_en = 0;
  int checks = 0, fails = 0, nrd = 0, nwr = 0;

  px565_unit u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_mirror(req_mirror), .req_r(req_r), .req_g(req_g), .req_b(req_b),
    .req_alpha(req_alpha), .req_word(req_word), .req_ready(req_ready),
    .out_valid(out_valid), .out_word(out_word), .out_r(out_r), .out_g(out_g),
    .out_b(out_b), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(rdata), .done(done));

  always @(posedge clk) begin
    if (load_en) stored <= load_val;
    else if (mem_wr) stored <= mem_wdata;
    if (mem_rd) rdata <= stored;
    if (mem_rd) nrd <= nrd + 1;
    if (mem_wr) nwr <= nwr + 1;
  end

  function automatic logic [4:0] rv5(input logic [4:0] v);
    for (int i = 0; i < 5; i++) rv5[i] = v[4-i];
  endfunction
  function automatic logic [5:0] rv6(input logic [5:0] v);
    for (int i = 0; i < 6; i++) rv6[i] = v[5-i];
  endfunction
  function automatic logic [15:0] e_pack(input logic [4:0] r, input logic [5:0] g,
                                         input logic [4:0] b, input logic m);
    e_pack = m ? {rv5(b), rv6(g), rv5(r)} : {b, g, r};
  endfunction
  function automatic int e_mix(input int n, input int o, input int a);
    e_mix = (n * a + o * (255 - a)) >> 8;
  endfunction
  function automatic logic [15:0] e_blend(input logic [15:0] w, input logic [4:0] r,
      input logic [5:0] g, input logic [4:0] b, input logic [7:0] a, input logic m);
    logic [4:0] orr, ob; logic [5:0] og;
    orr = m ? rv5(w[4:0]) : w[4:0];
    og  = m ? rv6(w[10:5]) : w[10:5];
    ob  = m ? rv5(w[15:11]) : w[15:11];
    e_blend = e_pack(5'(e_mix(r, orr, a)), 6'(e_mix(g, og, a)), 5'(e_mix(b, ob, a)), m);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_pack(input logic [4:0] r, input logic [5:0] g, input logic [4:0] b, input logic m);
    @(negedge clk);
    req_valid = 1; req_op = 2'b00; req_r = r; req_g = g; req_b = b; req_mirror = m;
    @(negedge clk);
    req_valid = 0;
    chk(m ? "R3 pack mirror" : "R1 pack", {out_valid, out_word}, {1'b1, e_pack(r, g, b, m)});
    @(negedge clk);
    chk("R1 valid one cycle", out_valid, 0);
  endtask

  task automatic do_unpack(input logic [15:0] w, input logic m);
    logic [4:0] er, eb; logic [5:0] eg;
    er = m ? rv5(w[4:0]) : w[4:0];
    eg = m ? rv6(w[10:5]) : w[10:5];
    eb = m ? rv5(w[15:11]) : w[15:11];
    @(negedge clk);
    req_valid = 1; req_op = 2'b01; req_word = w; req_mirror = m;
    @(negedge clk);
    req_valid = 0;
    chk(m ? "R3 unpack mirror" : "R2 unpack", {out_valid, out_b, out_g, out_r}, {1'b1, eb, eg, er});
  endtask

  task automatic do_blend(input logic [15:0] w, input logic [4:0] r, input logic [5:0] g,
                          input logic [4:0] b, input logic [7:0] a, input logic m);
    logic [15:0] exp;
    int rd0;
    exp = e_blend(w, r, g, b, a, m);
    @(negedge clk); load_en = 1; load_val = w;
    @(negedge clk); load_en = 0;
    rd0 = nrd;
    req_valid = 1; req_op = 2'b10; req_r = r; req_g = g; req_b = b; req_alpha = a; req_mirror = m;
    @(negedge clk);
    chk("R5 read after accept", {mem_rd, mem_wr, req_ready}, 3'b100);
    req_op = 2'b00;               // busy-time pack request, R7
    @(negedge clk);
    chk("R7 busy request ignored", {out_valid, mem_rd, req_ready}, 3'b000);
    @(negedge clk);
    chk("R5 write two after read", {mem_wr, mem_rd}, 2'b10);
    chk(m ? "R8 mirrored blend data" : "R4 blend data", mem_wdata, exp);
    @(negedge clk);
    req_valid = 0;
    chk("R6 done after write", {done, mem_wr, req_ready, out_valid}, 4'b1000);
    chk("R4 stored result", stored, exp);
    @(negedge clk);
    chk("R6 ready again", {req_ready, done}, 2'b10);
    chk("R7 single read per blend", nrd - rd0, 1);
  endtask

  initial begin
    #1600000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seed, w0;
    seed = 32'h5A17;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk("R9 reset outputs", {req_ready, out_valid, mem_rd, mem_wr, done}, 5'b10000);
    rst_n = 1;
    @(negedge clk);
    chk("R9 after reset", {req_ready, out_valid, mem_rd, mem_wr, done}, 5'b10000);

    do_pack(5'd1, 6'd0, 5'd0, 0);
    do_pack(5'd0, 6'd0, 5'd1, 0);
    do_pack(5'd1, 6'd1, 5'd1, 1);
    chk("R3 mirror single bits", out_word, 16'h8410);
    do_pack(5'h1F, 6'h3F, 5'h1F, 1);
    do_unpack(16'hF800, 0);
    do_unpack(16'h001F, 0);
    do_unpack(16'h8410, 1);

    w0 = nwr;
    @(negedge clk);
    req_valid = 1; req_op = 2'b11;
    @(negedge clk);
    req_valid = 0;
    chk("R10 spare op", {out_valid, mem_rd, req_ready}, 3'b001);
    @(negedge clk);
    chk("R10 spare op no access", {mem_rd, mem_wr, done, 32'(nwr - w0)}, 0);

    do_blend(16'h0000, 5'h1F, 6'h3F, 5'h1F, 8'd255, 0);
    chk("R4 alpha255 gives 30/62/30", stored, {5'd30, 6'd62, 5'd30});
    do_blend(16'hFFFF, 5'h00, 6'h00, 5'h00, 8'd0, 0);
    chk("R4 alpha0 gives 30/62/30", stored, {5'd30, 6'd62, 5'd30});
    do_blend(16'h8410, 5'd0, 6'd0, 5'd0, 8'd128, 1);
    do_blend(16'h1234, 5'd20, 6'd40, 5'd3, 8'd77, 1);

    for (int i = 0; i < 40; i++)
      do_pack(5'($urandom), 6'($urandom), 5'($urandom), 1'($urandom));
    for (int i = 0; i < 40; i++)
      do_unpack(16'($urandom), 1'($urandom));
    for (int i = 0; i < 30; i++)
      do_blend(16'($urandom), 5'($urandom), 6'($urandom), 5'($urandom), 8'($urandom), 1'($urandom));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule